// File: doc/BRIEF.md
# JTAG Vector Shift Engine

This block clocks a host-chosen number of test-clock cycles onto a four-wire JTAG port. The host writes a 32-bit mode-select vector and a 32-bit data-in vector into two registers, picks a test-clock divider, and then writes a control word that carries a cycle length and a start bit. The engine then runs. It presents the mode-select and data-in vectors one bit per test-clock cycle, lowest bit first. It captures the data-out line into a readback register on every cycle.

The engine does not decode the TAP state machine. The host must size the length field so that it matches the number of vector bits it wants to drive or capture. A transfer always runs for length + 1 cycles. Each test-clock half lasts a programmable number of system clocks, so the fastest test clock is half the system clock.

Top module: `jvs_engine`

The control flow is a three-state machine:
- `ST_IDLE` holds the test clock low.
- `ST_LOW` is the low half of a cycle.
- `ST_HIGH` is the high half of a cycle.

Its transitions are:
- START (`ST_IDLE`→`ST_LOW`): an accepted start request.
- RISE (`ST_LOW`→`ST_HIGH`): the low half ends. The data-out line is sampled here.
- FALL (`ST_HIGH`→`ST_LOW`): the high half ends and cycles remain. The vectors advance one bit.
- LAST (`ST_HIGH`→`ST_IDLE`): the final high half ends. The vectors advance and the engine goes idle.

## Requirements
- R1: After reset, the registers hold these values: control = 0x0FF (length 0xFF, not busy), divider = 0, mode vector = 0, data-in vector = 0, captured word = 0. TCK, TMS and TDI are low and `busy` is 0.
- R2: A write to address 0 with bit 8 set, made while idle, starts a transfer. `busy` is high from the next cycle. Control readback then shows bit 9 (busy) and bit 8 (request) set, and bits 7:0 hold the written length.
- R3: A transfer with length field L makes exactly L+1 TCK cycles, each with a rising and a falling edge. `busy` and control bits 9:8 clear after the final falling edge. TCK is low whenever the engine is idle.
- R4: The divider register (address 1, bits 7:0) holds D. Each TCK high half and each low half lasts D+1 system clocks, so consecutive rising edges are 2(D+1) clocks apart. D=0 gives the minimum ratio of 2.
- R5: `tms_o` and `tdi_o` present bit k of the mode vector (address 2) and data-in vector (address 3) during cycle k, counting from 0. They change only at a falling TCK edge. Cycles with k of 32 or more drive 0.
- R6: `tdo_i` is sampled at each rising TCK edge. The sample enters the captured word (address 4) at bit 31, and the earlier contents move one place toward bit 0.
- R7: After a transfer of L+1 cycles, the mode and data-in vectors read back shifted right by L+1 with zero fill. They read 0 when L+1 is 32 or more.
- R8: While `busy` is high, writes to every address are ignored. This includes a second start request, a new length, a new divider and new vectors.
- R9: Address map for reads:
  - 0: control. Bits 7:0 are the length, bit 8 is the request and bit 9 is busy.
  - 1: divider.
  - 2: mode vector.
  - 3: data-in vector.
  - 4: captured word.
  - Any other address reads 0.
  
  Writes to address 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from `addr` |
| busy | output | 1 | High while a transfer runs |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to the target |
| tdo_i | input | 1 | JTAG data from the target |

## Verification
The bench runs transfers of 1, 8, 32, 40 and 256 cycles at several divider settings, and checks every TMS and TDI bit as each TCK edge rises. Each corner case targets a specific fault:
- An off-by-one cycle counter makes one cycle too few or too many.
- Sampling the data-out line on the wrong edge, or entering it from the wrong end, scrambles the captured word.
- Shifting past bit 31 without zero fill puts stale ones on TMS in the 40-cycle run.
- A divider that counts D instead of D+1 shows up in the measured spacing between rising edges.
- Writes during a running transfer would restart or retime it, or corrupt the vectors. The bench catches this in the cycle count and in the readback that follows.

// File: rtl/jvs_pkg.sv
package jvs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } jvs_state_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
    localparam logic [ADDR_W-1:0] A_TMS  = 3'd2;
    localparam logic [ADDR_W-1:0] A_TDI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_TDO  = 3'd4;
endpackage

// File: rtl/jvs_halfclk.sv
// Counts system clocks within one TCK half; half_done marks its last clock.
module jvs_halfclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half_done
);
    logic [DIV_W-1:0] cnt_q;

    assign half_done = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || half_done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/jvs_ctrl.sv
// Transfer sequencer: idle, low half, high half; counts remaining cycles.
module jvs_ctrl
    import jvs_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] start_len,
    input  logic             half_done,
    output logic             busy,
    output logic             tck,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic [LEN_W-1:0] rem
);
    jvs_state_e       state_q, state_d;
    logic [LEN_W-1:0] rem_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_LOW;
            ST_LOW:  if (half_done) state_d = ST_HIGH;
            ST_HIGH: if (half_done) state_d = (rem_q == '0) ? ST_IDLE : ST_LOW;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        tck      = (state_q == ST_HIGH);
        rise_stb = (state_q == ST_LOW)  && half_done;
        fall_stb = (state_q == ST_HIGH) && half_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (start && (state_q == ST_IDLE)) begin
            rem_q <= start_len;
        end else if (fall_stb && (rem_q != '0)) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign rem = rem_q;
endmodule

// File: rtl/jvs_regs.sv
// Host register file: vectors shift in place, read mux, start decode.
module jvs_regs
    import jvs_pkg::*;
#(
    parameter int VEC_W = 32,
    parameter int LEN_W = 8,
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [VEC_W-1:0]  wdata,
    output logic [VEC_W-1:0]  rdata,
    input  logic              busy,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              tdo_bit,
    output logic              start,
    output logic [LEN_W-1:0]  start_len,
    output logic [LEN_W-1:0]  len,
    output logic [DIV_W-1:0]  div,
    output logic              tms_bit,
    output logic              tdi_bit
);
    localparam int GO_BIT   = LEN_W;
    localparam int BUSY_BIT = LEN_W + 1;

    logic [LEN_W-1:0] len_q;
    logic [DIV_W-1:0] div_q;
    logic [VEC_W-1:0] tms_q, tdi_q, tdo_q;
    logic             wr_ok;

    assign wr_ok     = wr_en && !busy;
    assign start     = wr_ok && (addr == A_CTRL) && wdata[GO_BIT];
    assign start_len = wdata[LEN_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '1;
            div_q <= '0;
            tms_q <= '0;
            tdi_q <= '0;
            tdo_q <= '0;
        end else begin
            if (wr_ok) begin
                case (addr)
                    A_CTRL:  len_q <= wdata[LEN_W-1:0];
                    A_DIV:   div_q <= wdata[DIV_W-1:0];
                    A_TMS:   tms_q <= wdata;
                    A_TDI:   tdi_q <= wdata;
                    default: ;
                endcase
            end
            if (fall_stb) begin
                tms_q <= tms_q >> 1;
                tdi_q <= tdi_q >> 1;
            end
            if (rise_stb) begin
                tdo_q <= {tdo_bit, tdo_q[VEC_W-1:1]};
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[LEN_W-1:0] = len_q;
                rdata[GO_BIT]    = busy;
                rdata[BUSY_BIT]  = busy;
            end
            A_DIV:   rdata[DIV_W-1:0] = div_q;
            A_TMS:   rdata = tms_q;
            A_TDI:   rdata = tdi_q;
            A_TDO:   rdata = tdo_q;
            default: rdata = '0;
        endcase
    end

    assign len     = len_q;
    assign div     = div_q;
    assign tms_bit = tms_q[0];
    assign tdi_bit = tdi_q[0];
endmodule

// File: rtl/jvs_engine.sv
module jvs_engine #(
    parameter int VEC_W = 32,
    parameter int LEN_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [VEC_W-1:0] wdata,
    output logic [VEC_W-1:0] rdata,
    output logic             busy,
    output logic             tck_o,
    output logic             tms_o,
    output logic             tdi_o,
    input  logic             tdo_i
);
    logic             start, half_done, rise_stb, fall_stb;
    logic [LEN_W-1:0] start_len, len_w, rem;
    logic [DIV_W-1:0] div_w;

    jvs_regs #(.VEC_W(VEC_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .tdo_bit(tdo_i),
        .start(start), .start_len(start_len), .len(len_w), .div(div_w),
        .tms_bit(tms_o), .tdi_bit(tdi_o)
    );

    jvs_halfclk #(.DIV_W(DIV_W)) u_half (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div_w),
        .half_done(half_done)
    );

    jvs_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
        .half_done(half_done), .busy(busy), .tck(tck_o),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .rem(rem)
    );
endmodule

// File: rtl/jvs_engine_chk.sv
module jvs_engine_chk #(
    parameter int LEN_W = 8,
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             tck_o,
    input logic             tms_o,
    input logic             tdi_o,
    input logic [LEN_W-1:0] rem,
    input logic [LEN_W-1:0] len,
    input logic [DIV_W-1:0] div
);
    logic [DIV_W:0] hi_cnt;
    logic [LEN_W:0] rise_cnt;
    logic           tck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt   <= '0;
            rise_cnt <= '0;
            tck_d    <= 1'b0;
        end else begin
            tck_d  <= tck_o;
            hi_cnt <= tck_o ? hi_cnt + 1'b1 : '0;
            if (!busy) begin
                rise_cnt <= '0;
            end else if (tck_o && !tck_d) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    p_idle_tck_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck_o);

    p_cycle_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (rise_cnt == ({1'b0, len} + 1'b1)));

    p_half_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tck_o) |-> (hi_cnt == ({1'b0, div} + 1'b1)));

    p_fall_only_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(tck_o)) |-> ($stable(tms_o) && $stable(tdi_o)));

    p_no_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (rem <= $past(rem)));
endmodule

bind jvs_engine jvs_engine_chk #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .tck_o(tck_o),
    .tms_o(tms_o), .tdi_o(tdi_o), .rem(rem), .len(len_w), .div(div_w)
);

// File: tb/jvs_engine_tb.sv
module jvs_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        busy, tck_o, tms_o, tdi_o;
    logic        tdo_i = 1'b0;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // fields: len[111:104] div[103:96] tms[95:64] tdi[63:32] tdo pattern[31:0]
    localparam logic [111:0] VECS [0:4] = '{
        {8'd7,   8'd0, 32'h0000_00A5, 32'h0000_003C, 32'h0000_00C9},
        {8'd31,  8'd2, 32'hDEAD_BEEF, 32'h1234_5678, 32'hF0F0_1234},
        {8'd39,  8'd1, 32'hFFFF_FFFF, 32'h8000_0001, 32'h5555_AAAA},
        {8'd0,   8'd0, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001},
        {8'd255, 8'd0, 32'h8000_0001, 32'h7FFF_FFFE, 32'h1357_9BDF}
    };

    jvs_engine u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .tck_o(tck_o),
        .tms_o(tms_o), .tdi_o(tdi_o), .tdo_i(tdo_i)
    );

    always #5 clk = ~clk;

    // model of the current transfer
    logic [31:0] m_tms, m_tdi, m_pat, tdo_model;
    int m_len, m_div;
    int rise_n, tms_err, tdi_err, per_err, cyc, last_rise;
    logic tck_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tck_o && !tck_prev) begin
                logic [31:0] st, sd;
                st = m_tms >> rise_n;
                sd = m_tdi >> rise_n;
                if (tms_o !== st[0]) tms_err++;
                if (tdi_o !== sd[0]) tdi_err++;
                if (rise_n > 0 && (cyc - last_rise) != 2 * (m_div + 1)) per_err++;
                last_rise = cyc;
                rise_n++;
            end
            if (!tck_o && tck_prev) tdo_i <= m_pat[rise_n % 32];
            tck_prev = tck_o;
            cyc++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic begin_xfer(input int len, input int div, input logic [31:0] tms,
                              input logic [31:0] tdi, input logic [31:0] pat);
        logic [31:0] r;
        wr(3'd1, div);
        wr(3'd2, tms);
        wr(3'd3, tdi);
        m_tms = tms; m_tdi = tdi; m_pat = pat; m_len = len; m_div = div;
        rise_n = 0; tms_err = 0; tdi_err = 0; per_err = 0;
        tdo_i = pat[0];
        for (int k = 0; k <= len; k++) tdo_model = {pat[k % 32], tdo_model[31:1]};
        wr(3'd0, 32'h100 | len);
        rd(3'd0, r);
        chk(r == (32'h300 | len), "R2 start readback", r, 32'h300 | len);
    endtask

    task automatic end_xfer(input string name);
        logic [31:0] r, e;
        int guard = 0;
        while (busy && guard < 100000) begin
            @(negedge clk);
            guard++;
        end
        chk(rise_n == m_len + 1, {"R3 cycle count ", name}, rise_n, m_len + 1);
        chk(tms_err == 0, {"R5 tms bits ", name}, tms_err, 0);
        chk(tdi_err == 0, {"R5 tdi bits ", name}, tdi_err, 0);
        chk(per_err == 0, {"R4 tck period ", name}, per_err, 0);
        rd(3'd0, r);
        chk(r == m_len, {"R3 busy and request cleared ", name}, r, m_len);
        rd(3'd4, r);
        chk(r == tdo_model, {"R6 captured word ", name}, r, tdo_model);
        rd(3'd2, r);
        e = (m_len + 1 >= 32) ? 32'h0 : (m_tms >> (m_len + 1));
        chk(r == e, {"R7 tms residue ", name}, r, e);
        rd(3'd3, r);
        e = (m_len + 1 >= 32) ? 32'h0 : (m_tdi >> (m_len + 1));
        chk(r == e, {"R7 tdi residue ", name}, r, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        tdo_model = '0;
        m_tms = '0; m_tdi = '0; m_pat = '0; m_len = 0; m_div = 0; cyc = 0; last_rise = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk(!tck_o && !tms_o && !tdi_o && !busy, "R1 pins idle", {tck_o, tms_o, tdi_o, busy}, 0);
        rd(3'd0, r); chk(r == 32'h0FF, "R1 control reset", r, 32'h0FF);
        rd(3'd1, r); chk(r == 0, "R1 divider reset", r, 0);
        rd(3'd2, r); chk(r == 0, "R1 tms reset", r, 0);
        rd(3'd3, r); chk(r == 0, "R1 tdi reset", r, 0);
        rd(3'd4, r); chk(r == 0, "R1 tdo reset", r, 0);
        rd(3'd5, r); chk(r == 0, "R9 unmapped address", r, 0);

        // table walk: R2..R7
        for (int i = 0; i < 5; i++) begin
            logic [111:0] v;
            v = VECS[i];
            begin_xfer(v[111:104], v[103:96], v[95:64], v[63:32], v[31:0]);
            end_xfer($sformatf("vector %0d", i));
        end

        // R8: writes during a transfer are ignored
        begin_xfer(15, 3, 32'hF0F0_A5A5, 32'h8001_0003, 32'h0BAD_CAFE);
        repeat (5) @(negedge clk);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0);
        wr(3'd1, 32'd7);
        wr(3'd0, 32'h103);
        chk(busy, "R8 still busy after writes", busy, 1);
        end_xfer("R8 writes while busy");
        rd(3'd1, r); chk(r == 3, "R8 divider unchanged", r, 3);

        // R9: captured word is read-only
        wr(3'd4, 32'h1234_5678);
        rd(3'd4, r); chk(r == tdo_model, "R9 tdo write ignored", r, tdo_model);
        chk(!tck_o, "R3 tck low when idle", tck_o, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule